// File: doc/BRIEF.md
# Strobed Serial Command Port for a Segment Display Controller

This block is the host-facing side of a segment display controller. A host drives a strobe (active low), a shift clock and one data line. Each strobe-low period is one transfer. The first eight bits of a transfer are a command byte. Depending on that command, the bits that follow are either 56-bit display words or ignored. In read mode the port itself drives the data line with 32 bits of key data.

The command has two forms:

- **Status command:** picks a latch row, a display mode and the direction.
- **Display-setting command:** picks the duty, the frame divider, the drive source, master or slave, and test mode.

A completed command takes effect when the strobe returns high. Display words are written into the addressed row of a four-row output latch as soon as each word completes. Key data leaves through an open-drain enable, so the line is only ever pulled low.

The shift clock, strobe and data inputs are oversampled by the system clock through a two-stage synchronizer with edge detection. All logic runs in the single system clock domain.

Top module: `strobe_cmd_port`

## Requirements
- R1: After reset, every configuration output is zero: duty 0, frame divider 0, drive source internal (0), master (0), test mode off, display off, latch row 0 and write direction. The data line is released and no latch write occurs.
- R2: Bits are captured on rising shift-clock edges, most significant bit first. The first eight bits after the strobe falls form the command, and bit 7 selects the command kind (1 = status, 0 = display setting).
- R3: After a status command with bit 0 = 0 (write), each following group of 56 bits is written as one word to the latch. The write is a one-cycle `lat_we` pulse, and `lat_row` equals command bits 4:3. The first bit received lands in `lat_wdata[55]` (segment 1). Consecutive words go to the same row.
- R4: A status command, applied at the strobe rise, does three things. It sets `row_sel` from bits 4:3 and `read_mode` from bit 0. It sets the display from bits 2:1: 00 turns the display off, 10 turns it on, and 01 and 11 leave it unchanged.
- R5: A display-setting command, applied at the strobe rise, sets duty from bits 1:0, frame divider from bits 3:2, external drive from bit 4, slave from bit 5 and test mode from bit 6. If these seven bits differ from the current setting, the display (and key scanning) is forced off. If they are equal, nothing changes.
- R6: Configuration outputs change only after a strobe rise. A transfer whose strobe rises before its eighth bit has no effect.
- R7: A strobe rise or fall in the middle of a word discards only that partial word. Words completed earlier stay written, and the next transfer again starts with a command byte.
- R8: After a status command with bit 0 = 1 (read), each falling shift-clock edge after the command presents the next key bit, most significant first. `sdio_pull_low` is 1 exactly when the presented bit is 0. The line is released after 32 bits and whenever the strobe is high.
- R9: Bits that follow a read command or a display-setting command never write the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Transfer strobe, low while a transfer is open |
| sck | input | 1 | Host shift clock |
| sdio_in | input | 1 | Level seen on the shared data line |
| key_snapshot | input | 32 | Key matrix state, bit 31 sent first |
| sdio_pull_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| duty_sel | output | 2 | Duty selection |
| frame_div_sel | output | 2 | Frame divider selection |
| ext_drive | output | 1 | 1 selects the external drive voltage source |
| slave_mode | output | 1 | 1 selects slave operation |
| test_mode | output | 1 | 1 selects test mode |
| display_on | output | 1 | Display and key scanning enabled |
| row_sel | output | 2 | Latch row held from the last status command |
| read_mode | output | 1 | Direction held from the last status command |
| lat_we | output | 1 | One-cycle latch write strobe |
| lat_row | output | 2 | Row for the latch write |
| lat_wdata | output | 56 | Word for the latch write, bit 55 = segment 1 |

## Verification
Two functions can land on the same system-clock cycle:

- the write of the final display word, triggered by the last shift-clock rise;
- the commit of the transfer's command, triggered by the strobe rise.

The same collision happens when a command's eighth bit coincides with the strobe rise. The bench provokes both cases by raising the shift clock and the strobe on the same clock edge, so that both pass through the synchronizer together. It then judges three things. The word must appear on the row named by that transfer's own command. The command must still be committed. No earlier setting may be disturbed.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = 56;
    localparam int KEY_BITS  = 32;
    localparam int ROW_COUNT = 4;
    localparam int ROW_AW    = $clog2(ROW_COUNT);

    // display request field of the status command
    typedef enum logic [1:0] {
        DSP_OFF    = 2'b00,
        DSP_RSVD   = 2'b01,
        DSP_NORMAL = 2'b10,
        DSP_KEEP   = 2'b11
    } disp_req_e;

    typedef struct packed {
        logic        is_status;
        logic [1:0]  spare;
        logic [1:0]  row;
        disp_req_e   disp;
        logic        rd;
    } status_cmd_t;

    typedef struct packed {
        logic        is_status;
        logic        test;
        logic        slave;
        logic        ext;
        logic [1:0]  frame;
        logic [1:0]  duty;
    } setting_cmd_t;

    typedef struct packed {
        logic        test;
        logic        slave;
        logic        ext;
        logic [1:0]  frame;
        logic [1:0]  duty;
    } setting_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } rx_phase_e;

    function automatic setting_t to_setting(setting_cmd_t c);
        setting_t s;
        s.test  = c.test;
        s.slave = c.slave;
        s.ext   = c.ext;
        s.frame = c.frame;
        s.duty  = c.duty;
        return s;
    endfunction

    function automatic logic disp_next(disp_req_e r, logic cur);
        case (r)
            DSP_OFF:    return 1'b0;
            DSP_NORMAL: return 1'b1;
            default:    return cur;
        endcase
    endfunction

    function automatic rx_phase_e phase_after(logic [CMD_BITS-1:0] cmd);
        status_cmd_t s;
        s = status_cmd_t'(cmd);
        if (!s.is_status) return PH_SKIP;
        if (s.rd)         return PH_READ;
        return PH_WRITE;
    endfunction

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
    parameter int W = 3,
    parameter int E = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [E-1:0] rise,
    output logic [E-1:0] fall
);
    logic [W-1:0] s1, s2;
    logic [E-1:0] s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
            s3 <= RST_VAL[E-1:0];
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2[E-1:0];
        end
    end

    assign lvl  = s2;
    assign rise = s2[E-1:0] & ~s3;
    assign fall = ~s2[E-1:0] & s3;

endmodule

// File: rtl/sp_rx_frame.sv
module sp_rx_frame
    import strobe_port_pkg::*;
#(
    parameter int CBITS = CMD_BITS,
    parameter int WBITS = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_fall,
    input  logic              stb_rise,
    input  logic              sck_rise,
    input  logic              sdi,
    output logic              cmd_valid,
    output logic [CBITS-1:0]  cmd_byte,
    output logic              xfer_end,
    output logic              read_start,
    output logic              lat_we,
    output logic [ROW_AW-1:0] lat_row,
    output logic [WBITS-1:0]  lat_wdata
);
    localparam int CNT_W = $clog2(WBITS);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CBITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WBITS - 1);

    rx_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic [CBITS-2:0] cmd_sh;
    logic [WBITS-2:0] word_q;
    logic             xfer_open;
    logic [CBITS-1:0] cmd_next;
    logic [WBITS-1:0] word_next;
    status_cmd_t      st_q;

    assign cmd_next  = {cmd_sh, sdi};
    assign word_next = {word_q, sdi};
    assign st_q      = status_cmd_t'(cmd_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            cnt        <= '0;
            cmd_sh     <= '0;
            cmd_byte   <= '0;
            cmd_valid  <= 1'b0;
            word_q     <= '0;
            xfer_open  <= 1'b0;
            xfer_end   <= 1'b0;
            read_start <= 1'b0;
            lat_we     <= 1'b0;
            lat_row    <= '0;
            lat_wdata  <= '0;
        end else begin
            lat_we     <= 1'b0;
            read_start <= 1'b0;
            xfer_end   <= 1'b0;
            if (stb_fall) begin
                // new transfer: any partial unit is dropped
                phase     <= PH_CMD;
                cnt       <= '0;
                cmd_valid <= 1'b0;
                xfer_open <= 1'b1;
            end else begin
                if (xfer_open && sck_rise) begin
                    case (phase)
                        PH_CMD: begin
                            cmd_sh <= cmd_next[CBITS-2:0];
                            if (cnt == CMD_LAST) begin
                                cnt        <= '0;
                                cmd_byte   <= cmd_next;
                                cmd_valid  <= 1'b1;
                                phase      <= phase_after(cmd_next);
                                read_start <= (phase_after(cmd_next) == PH_READ);
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        PH_WRITE: begin
                            word_q <= word_next[WBITS-2:0];
                            if (cnt == WORD_LAST) begin
                                cnt       <= '0;
                                lat_we    <= 1'b1;
                                lat_row   <= st_q.row;
                                lat_wdata <= word_next;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                // the last bit of a transfer is taken before it closes
                if (stb_rise && xfer_open) begin
                    xfer_open <= 1'b0;
                    xfer_end  <= 1'b1;
                end
            end
        end
    end

    AST_WRITE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lat_we |=> !lat_we); // R3

endmodule

// File: rtl/sp_key_tx.sv
module sp_key_tx
    import strobe_port_pkg::*;
#(
    parameter int KBITS = KEY_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [KBITS-1:0] key_in,
    input  logic             sck_fall,
    input  logic             stb_lvl,
    output logic             pull_low
);
    localparam int CNT_W = $clog2(KBITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KBITS);

    logic [KBITS-1:0] sh;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             drive;
    logic             bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            cnt   <= '0;
            armed <= 1'b0;
            drive <= 1'b0;
            bit_q <= 1'b1;
        end else if (stb_lvl) begin
            armed <= 1'b0;
            drive <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            sh    <= key_in;
            armed <= 1'b1;
            cnt   <= '0;
            drive <= 1'b0;
        end else if (armed && sck_fall) begin
            if (cnt == LAST) begin
                drive <= 1'b0;
                armed <= 1'b0;
            end else begin
                bit_q <= sh[KBITS-1];
                sh    <= {sh[KBITS-2:0], 1'b0};
                drive <= 1'b1;
                cnt   <= cnt + 1'b1;
            end
        end
    end

    assign pull_low = drive & ~bit_q;

endmodule

// File: rtl/sp_cfg_regs.sv
module sp_cfg_regs
    import strobe_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer_end,
    input  logic                cmd_valid,
    input  logic [CMD_BITS-1:0] cmd_byte,
    output setting_t            setting_q,
    output logic                display_on,
    output logic [ROW_AW-1:0]   row_q,
    output logic                read_q
);
    status_cmd_t st;
    setting_t    req;

    assign st  = status_cmd_t'(cmd_byte);
    assign req = to_setting(setting_cmd_t'(cmd_byte));

    always_ff @(posedge clk) begin
        if (rst) begin
            setting_q  <= '0;
            display_on <= 1'b0;
            row_q      <= '0;
            read_q     <= 1'b0;
        end else if (xfer_end && cmd_valid) begin
            if (st.is_status) begin
                row_q      <= st.row;
                read_q     <= st.rd;
                display_on <= disp_next(st.disp, display_on);
            end else if (req != setting_q) begin
                setting_q  <= req;
                display_on <= 1'b0;
            end
        end
    end

    AST_CFG_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !xfer_end |=> ($stable(setting_q) && $stable(display_on)
                       && $stable(row_q) && $stable(read_q))); // R6

    AST_SETTING_CHANGE_BLANKS: assert property (@(posedge clk) disable iff (rst)
        !$stable(setting_q) |-> !display_on); // R5

endmodule

// File: rtl/strobe_cmd_port.sv
module strobe_cmd_port
    import strobe_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe_n,
    input  logic                 sck,
    input  logic                 sdio_in,
    input  logic [KEY_BITS-1:0]  key_snapshot,
    output logic                 sdio_pull_low,
    output logic [1:0]           duty_sel,
    output logic [1:0]           frame_div_sel,
    output logic                 ext_drive,
    output logic                 slave_mode,
    output logic                 test_mode,
    output logic                 display_on,
    output logic [ROW_AW-1:0]    row_sel,
    output logic                 read_mode,
    output logic                 lat_we,
    output logic [ROW_AW-1:0]    lat_row,
    output logic [WORD_BITS-1:0] lat_wdata
);
    logic [2:0]          lvl;
    logic [1:0]          rise, fall;
    logic                stb_lvl, sck_lvl, sdi;
    logic                cmd_valid, xfer_end, read_start;
    logic [CMD_BITS-1:0] cmd_byte;
    setting_t            setting;

    // bit 0 strobe, bit 1 shift clock, bit 2 data (level only)
    sp_sync_edge #(.W(3), .E(2), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sdio_in, sck, strobe_n}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign stb_lvl = lvl[0];
    assign sck_lvl = lvl[1];
    assign sdi     = lvl[2];

    sp_rx_frame u_rx (
        .clk        (clk),
        .rst        (rst),
        .stb_fall   (fall[0]),
        .stb_rise   (rise[0]),
        .sck_rise   (rise[1]),
        .sdi        (sdi),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .xfer_end   (xfer_end),
        .read_start (read_start),
        .lat_we     (lat_we),
        .lat_row    (lat_row),
        .lat_wdata  (lat_wdata)
    );

    sp_key_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (read_start),
        .key_in   (key_snapshot),
        .sck_fall (fall[1]),
        .stb_lvl  (stb_lvl),
        .pull_low (sdio_pull_low)
    );

    sp_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .xfer_end   (xfer_end),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .setting_q  (setting),
        .display_on (display_on),
        .row_q      (row_sel),
        .read_q     (read_mode)
    );

    assign duty_sel      = setting.duty;
    assign frame_div_sel = setting.frame;
    assign ext_drive     = setting.ext;
    assign slave_mode    = setting.slave;
    assign test_mode     = setting.test;

    AST_PULL_ON_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdio_pull_low) |-> (!sck_lvl || stb_lvl)); // R8

    AST_RELEASE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        stb_lvl |=> !sdio_pull_low); // R8

    AST_NO_WRITE_WHILE_PULLING: assert property (@(posedge clk) disable iff (rst)
        lat_we |-> !sdio_pull_low); // R9

endmodule

// File: tb/strobe_cmd_port_test.sv
module strobe_cmd_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdio_in = 1'b1;
    logic [31:0] keys = '0;
    logic        pull;
    logic [1:0]  duty, frame, row, lrow;
    logic        ext, slave, test, disp, rd, we;
    logic [55:0] wdata;

    localparam logic [55:0] W1 = 56'hC35A960F1E2D78;
    localparam logic [55:0] W2 = 56'h0123456789ABCD;
    localparam logic [31:0] KEYS = 32'hA5C30F96;

    int checks = 0;
    int fails  = 0;
    int wr_n   = 0;
    logic [55:0] wr_data [0:15];
    logic [1:0]  wr_row  [0:15];

    always #2.5 clk = ~clk;

    strobe_cmd_port uut (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .sck(sck), .sdio_in(sdio_in),
        .key_snapshot(keys), .sdio_pull_low(pull), .duty_sel(duty),
        .frame_div_sel(frame), .ext_drive(ext), .slave_mode(slave),
        .test_mode(test), .display_on(disp), .row_sel(row), .read_mode(rd),
        .lat_we(we), .lat_row(lrow), .lat_wdata(wdata)
    );

    // records every latch write seen at the port
    always @(negedge clk) begin
        if (!rst && we) begin
            if (wr_n < 16) begin
                wr_data[wr_n] = wdata;
                wr_row[wr_n]  = lrow;
            end
            wr_n = wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_xfer();
        strobe_n = 1'b0;
        wait_n(8);
    endtask

    task automatic end_xfer();
        strobe_n = 1'b1;
        wait_n(12);
    endtask

    // sends n bits of v, MSB first; if close, strobe rises with the last clock rise
    task automatic send_bits(input logic [63:0] v, input int n, input bit close);
        for (int i = n - 1; i >= 0; i--) begin
            sck = 1'b0;
            sdio_in = v[i];
            wait_n(8);
            sck = 1'b1;
            if (close && i == 0) strobe_n = 1'b1;
            wait_n(8);
        end
        sdio_in = 1'b1;
        if (close) wait_n(12);
    endtask

    task automatic xfer_cmd(input logic [7:0] c);
        begin_xfer();
        send_bits({56'd0, c}, 8, 1'b0);
        end_xfer();
    endtask

    task automatic read_bits(input int n, input logic [31:0] exp);
        for (int k = 0; k < n; k++) begin
            sck = 1'b0;
            wait_n(8);
            chk_eq($sformatf("R8 key bit %0d pull", 31 - k), pull, !exp[31 - k]);
            sck = 1'b1;
            wait_n(8);
        end
    endtask

    task automatic t_reset();
        chk_eq("R1 duty", duty, 0);
        chk_eq("R1 frame", frame, 0);
        chk_eq("R1 ext/slave/test", {ext, slave, test}, 0);
        chk_eq("R1 display", disp, 0);
        chk_eq("R1 row/read", {row, rd}, 0);
        chk_eq("R1 pull released", pull, 0);
        chk_eq("R1 no write", wr_n, 0);
    endtask

    task automatic t_setting();
        xfer_cmd(8'h2D);
        chk_eq("R5 R2 duty", duty, 2'd1);
        chk_eq("R5 frame", frame, 2'd3);
        chk_eq("R5 ext,slave,test", {ext, slave, test}, 3'b010);
        chk_eq("R5 display off", disp, 0);
    endtask

    task automatic t_write();
        begin_xfer();
        send_bits({56'd0, 8'h94}, 8, 1'b0);
        send_bits({8'd0, W1}, 56, 1'b0);
        chk_eq("R6 display before strobe rise", disp, 0);
        send_bits({8'd0, W2}, 56, 1'b0);
        end_xfer();
        chk_eq("R3 write count", wr_n, 2);
        chk_eq("R3 first word", wr_data[0], W1);
        chk_eq("R3 second word", wr_data[1], W2);
        chk_eq("R3 rows", {wr_row[0], wr_row[1]}, 4'b1010);
        chk_eq("R4 display on", disp, 1);
        chk_eq("R4 row_sel", row, 2);
        chk_eq("R4 read_mode", rd, 0);
    endtask

    task automatic t_same_setting();
        xfer_cmd(8'h2D);
        chk_eq("R5 same setting keeps display", disp, 1);
        chk_eq("R5 same setting keeps duty", duty, 1);
        xfer_cmd(8'h40);
        chk_eq("R5 new setting blanks display", disp, 0);
        chk_eq("R5 new setting fields", {test, slave, ext, frame, duty}, 7'b1000000);
        xfer_cmd(8'h00);
        chk_eq("R5 test mode cleared", test, 0);
    endtask

    task automatic t_disp_field();
        xfer_cmd(8'h84);
        chk_eq("R4 field 10 on", disp, 1);
        xfer_cmd(8'h8A);
        chk_eq("R4 field 01 keeps", disp, 1);
        chk_eq("R4 row 1", row, 1);
        xfer_cmd(8'h8E);
        chk_eq("R4 field 11 keeps", disp, 1);
        xfer_cmd(8'h98);
        chk_eq("R4 field 00 off", disp, 0);
        chk_eq("R4 row 3", row, 3);
    endtask

    task automatic t_partial();
        begin_xfer();
        send_bits(64'h10, 5, 1'b0);
        end_xfer();
        chk_eq("R6 partial command display", disp, 0);
        chk_eq("R6 partial command row", row, 3);
    endtask

    task automatic t_abort();
        int base;
        base = wr_n;
        begin_xfer();
        send_bits({56'd0, 8'h9C}, 8, 1'b0);
        send_bits({8'd0, W1}, 56, 1'b0);
        send_bits({8'd0, W2} >> 36, 20, 1'b0);
        end_xfer();
        chk_eq("R7 only full word written", wr_n - base, 1);
        chk_eq("R7 full word row/data", {wr_row[base], wr_data[base]}, {2'd3, W1});
        begin_xfer();
        send_bits({56'd0, 8'h84}, 8, 1'b0);
        send_bits({8'd0, W2}, 56, 1'b0);
        end_xfer();
        chk_eq("R7 next transfer starts with command", wr_n - base, 2);
        chk_eq("R7 new row/data", {wr_row[base + 1], wr_data[base + 1]}, {2'd0, W2});
    endtask

    task automatic t_read();
        int base;
        base = wr_n;
        keys = KEYS;
        begin_xfer();
        send_bits({56'd0, 8'h85}, 8, 1'b0);
        wait_n(8);
        read_bits(32, KEYS);
        sck = 1'b0;
        wait_n(8);
        chk_eq("R8 released after 32 bits", pull, 0);
        sck = 1'b1;
        wait_n(8);
        send_bits({8'd0, W1}, 56, 1'b0);
        end_xfer();
        chk_eq("R9 no write in read mode", wr_n - base, 0);
        chk_eq("R4 read_mode set", rd, 1);
        chk_eq("R8 released when strobe high", pull, 0);
        begin_xfer();
        send_bits({56'd0, 8'h85}, 8, 1'b0);
        read_bits(2, KEYS);
        strobe_n = 1'b1;
        wait_n(5);
        chk_eq("R8 strobe rise mid-read releases", pull, 0);
        wait_n(8);
    endtask

    task automatic t_setting_skip();
        int base;
        base = wr_n;
        begin_xfer();
        send_bits({56'd0, 8'h00}, 8, 1'b0);
        send_bits({8'd0, W2}, 56, 1'b0);
        end_xfer();
        chk_eq("R9 no write after setting command", wr_n - base, 0);
    endtask

    task automatic t_coincide();
        int base;
        base = wr_n;
        begin_xfer();
        send_bits({56'd0, 8'h8C}, 8, 1'b1);
        chk_eq("R6 R4 command ending with strobe commits row", row, 1);
        chk_eq("R4 command ending with strobe commits display", {disp, rd}, 2'b10);
        begin_xfer();
        send_bits({56'd0, 8'h9C}, 8, 1'b0);
        send_bits({8'd0, W2}, 56, 1'b1);
        chk_eq("R3 word ending with strobe written", wr_n - base, 1);
        chk_eq("R3 coincident word row/data", {wr_row[base], wr_data[base]}, {2'd3, W2});
        chk_eq("R4 coincident commit row", row, 3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        t_reset();
        t_setting();
        t_write();
        t_same_setting();
        t_disp_field();
        t_partial();
        t_abort();
        t_read();
        t_setting_skip();
        t_coincide();
        finish_run();
    end

endmodule